// File: doc/BRIEF.md
# Single-Bus Accumulator Datapath

This block is the register-transfer core of a small accumulator machine. A word-addressed main memory and six working registers (program counter, memory address, instruction, memory data, accumulator and a scratch register that takes the adder result) all exchange data over one internal bus. At most one register drives that bus in a cycle. Any number of registers may capture it at the clock edge.

An external sequencer drives the block with individual strobes every cycle. Each strobe names one action: place a register on the bus, capture the bus into a register, advance the program counter, read or write memory, or add. The datapath returns two things to the sequencer: a flag that is high while the accumulator is zero, and the operation field of the instruction register. An addition leaves its sum in the scratch register, so a later cycle must move it to the accumulator. Memory is filled through a separate preload port while reset is held. All registers can be observed on dedicated outputs.

Top module: `acc_bus_datapath`

## Requirements
- R1: While `rst_n` is low, and on its release, the registers `pc_q`, `mar_q`, `ir_q`, `mdr_q`, `acc_q` and `tmp_q` read zero, and `acc_zero` is 1.
- R2: At most one of `drv_acc`, `drv_ir`, `drv_pc`, `drv_mdr`, `drv_tmp` is high in a cycle. With none high the bus carries zero. `drv_ir` places only IR bits 9:0 on the bus, with bits 11:10 at zero. PC is zero-extended to 12 bits.
- R3: Each load strobe (`ld_acc`, `ld_ir`, `ld_mar`) captures the bus at the rising edge, and the 10-bit MAR keeps bus bits 9:0. A register whose load strobe is low keeps its value.
- R4: `mem_rd` loads MDR with the memory word at address MAR, and the value shows on `mdr_q` after that edge. When `ld_mdr` and `mem_rd` are both high, MDR takes the bus.
- R5: `mem_wr` stores the current MDR into the word at address MAR. A `mem_rd` in the same cycle returns the word as it was before the write.
- R6: `add_en` loads TMP with the bus value plus MDR, modulo 4096. For example, 0x002 + 0xFFF gives 0x001.
- R7: `inc_pc` adds one to PC and wraps from 1023 to 0. It may share a cycle with `mem_rd`. `ld_pc` loads PC from bus bits 9:0 and takes priority over `inc_pc`.
- R8: `acc_zero` is high exactly when ACC is zero. `opcode` equals IR bits 11:10. Neither output has a cycle of delay.
- R9: While `rst_n` is low, `pre_we` writes `pre_data` into the word at address `pre_addr` on each rising edge. While `rst_n` is high, `pre_we` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low asynchronous reset of the registers |
| ld_acc | input | 1 | Capture bus into ACC |
| drv_acc | input | 1 | ACC drives the bus |
| ld_ir | input | 1 | Capture bus into IR |
| drv_ir | input | 1 | IR address field drives the bus |
| ld_pc | input | 1 | Capture bus bits 9:0 into PC |
| drv_pc | input | 1 | PC drives the bus |
| inc_pc | input | 1 | Increment PC |
| ld_mar | input | 1 | Capture bus bits 9:0 into MAR |
| ld_mdr | input | 1 | Capture bus into MDR |
| drv_mdr | input | 1 | MDR drives the bus |
| mem_rd | input | 1 | Load MDR from memory at MAR |
| mem_wr | input | 1 | Store MDR into memory at MAR |
| add_en | input | 1 | Load TMP with bus plus MDR |
| drv_tmp | input | 1 | TMP drives the bus |
| pre_we | input | 1 | Preload write enable, honoured only in reset |
| pre_addr | input | 10 | Preload word address |
| pre_data | input | 12 | Preload word value |
| acc_zero | output | 1 | ACC equals zero |
| opcode | output | 2 | IR bits 11:10 |
| pc_q | output | 10 | PC contents |
| mar_q | output | 10 | MAR contents |
| ir_q | output | 12 | IR contents |
| mdr_q | output | 12 | MDR contents |
| acc_q | output | 12 | ACC contents |
| tmp_q | output | 12 | TMP contents |

## Verification
Every register change, including the memory read into MDR and a store, takes effect at the single rising edge where its strobe is sampled, so it is due exactly one cycle after the strobe is applied. The bench changes strobes on the falling edge, lets one rising edge pass, and compares every register output at the next falling edge. At that point the behavioural model has advanced by exactly one step. `acc_zero` and `opcode` follow the registers with no extra cycle, so they are compared at the same falling edge. A store is confirmed by reading the same word back through MDR in a following cycle.

// File: rtl/acc_dp_pkg.sv
package acc_dp_pkg;
   // bus source slots, in the order the bus mux select vector uses them
   localparam int unsigned SRC_ACC = 0;
   localparam int unsigned SRC_IR  = 1;
   localparam int unsigned SRC_PC  = 2;
   localparam int unsigned SRC_MDR = 3;
   localparam int unsigned SRC_TMP = 4;
   localparam int unsigned N_SRC   = 5;
endpackage

// File: rtl/dp_bus_mux.sv
module dp_bus_mux #(
   parameter int unsigned W = 12,
   parameter int unsigned N = 5
) (
   input  logic [N-1:0]        sel,
   input  logic [N-1:0][W-1:0] src,
   output logic [W-1:0]        bus
);
   if (N < 1) begin : g_bad_n
      $error("dp_bus_mux: N must be at least 1");
   end

   logic [N-1:0][W-1:0] gated;

   for (genvar g = 0; g < N; g++) begin : g_gate
      assign gated[g] = src[g] & {W{sel[g]}};
   end

   always_comb begin
      bus = '0;
      for (int i = 0; i < N; i++) bus = bus | gated[i];
   end
endmodule

// File: rtl/dp_reg.sv
module dp_reg #(
   parameter int unsigned W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ld,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (ld) q <= d;
   end
endmodule

// File: rtl/dp_mem.sv
module dp_mem #(
   parameter int unsigned AW = 10,
   parameter int unsigned DW = 12
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);
   localparam int unsigned DEPTH = 1 << AW;

   logic [DW-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) cells[addr] <= wdata;
   end

   // read is combinational: a capture in the same edge as a write sees the old word
   assign rdata = cells[addr];
endmodule

// File: rtl/acc_bus_datapath.sv
module acc_bus_datapath #(
   parameter int unsigned ADDR_W = 10,
   parameter int unsigned OPC_W  = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      ld_acc,
   input  logic                      drv_acc,
   input  logic                      ld_ir,
   input  logic                      drv_ir,
   input  logic                      ld_pc,
   input  logic                      drv_pc,
   input  logic                      inc_pc,
   input  logic                      ld_mar,
   input  logic                      ld_mdr,
   input  logic                      drv_mdr,
   input  logic                      mem_rd,
   input  logic                      mem_wr,
   input  logic                      add_en,
   input  logic                      drv_tmp,
   input  logic                      pre_we,
   input  logic [ADDR_W-1:0]         pre_addr,
   input  logic [ADDR_W+OPC_W-1:0]   pre_data,
   output logic                      acc_zero,
   output logic [OPC_W-1:0]          opcode,
   output logic [ADDR_W-1:0]         pc_q,
   output logic [ADDR_W-1:0]         mar_q,
   output logic [ADDR_W+OPC_W-1:0]   ir_q,
   output logic [ADDR_W+OPC_W-1:0]   mdr_q,
   output logic [ADDR_W+OPC_W-1:0]   acc_q,
   output logic [ADDR_W+OPC_W-1:0]   tmp_q
);
   import acc_dp_pkg::*;

   localparam int unsigned WORD_W = ADDR_W + OPC_W;

   if (ADDR_W < 2 || ADDR_W > 16) begin : g_bad_addr
      $error("acc_bus_datapath: ADDR_W out of range 2..16");
   end
   if (OPC_W < 1 || OPC_W > 4) begin : g_bad_opc
      $error("acc_bus_datapath: OPC_W out of range 1..4");
   end

   logic [WORD_W-1:0]             bus;
   logic [N_SRC-1:0]              sel;
   logic [N_SRC-1:0][WORD_W-1:0]  src;
   logic [WORD_W-1:0]             sum;
   logic [WORD_W-1:0]             mem_q;
   logic                          m_we;
   logic [ADDR_W-1:0]             m_addr;
   logic [WORD_W-1:0]             m_wdata;

   // ---------------- shared bus ----------------
   assign sel[SRC_ACC] = drv_acc;
   assign sel[SRC_IR]  = drv_ir;
   assign sel[SRC_PC]  = drv_pc;
   assign sel[SRC_MDR] = drv_mdr;
   assign sel[SRC_TMP] = drv_tmp;

   assign src[SRC_ACC] = acc_q;
   assign src[SRC_IR]  = {{OPC_W{1'b0}}, ir_q[ADDR_W-1:0]};
   assign src[SRC_PC]  = {{OPC_W{1'b0}}, pc_q};
   assign src[SRC_MDR] = mdr_q;
   assign src[SRC_TMP] = tmp_q;

   dp_bus_mux #(.W(WORD_W), .N(N_SRC)) u_bus (
      .sel (sel),
      .src (src),
      .bus (bus)
   );

   // ---------------- plain load registers ----------------
   dp_reg #(.W(WORD_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .ld(ld_acc), .d(bus), .q(acc_q)
   );
   dp_reg #(.W(WORD_W)) u_ir (
      .clk(clk), .rst_n(rst_n), .ld(ld_ir), .d(bus), .q(ir_q)
   );
   dp_reg #(.W(ADDR_W)) u_mar (
      .clk(clk), .rst_n(rst_n), .ld(ld_mar), .d(bus[ADDR_W-1:0]), .q(mar_q)
   );

   // adder result only ever lands in TMP
   assign sum = bus + mdr_q;
   dp_reg #(.W(WORD_W)) u_tmp (
      .clk(clk), .rst_n(rst_n), .ld(add_en), .d(sum), .q(tmp_q)
   );

   // ---------------- PC: bus load beats increment ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pc_q <= '0;
      else if (ld_pc)  pc_q <= bus[ADDR_W-1:0];
      else if (inc_pc) pc_q <= pc_q + 1'b1;
   end

   // ---------------- MDR: bus load beats memory read ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mdr_q <= '0;
      else if (ld_mdr) mdr_q <= bus;
      else if (mem_rd) mdr_q <= mem_q;
   end

   // ---------------- memory, preload port owns it during reset ----------------
   assign m_we    = rst_n ? mem_wr : pre_we;
   assign m_addr  = rst_n ? mar_q  : pre_addr;
   assign m_wdata = rst_n ? mdr_q  : pre_data;

   dp_mem #(.AW(ADDR_W), .DW(WORD_W)) u_mem (
      .clk   (clk),
      .we    (m_we),
      .addr  (m_addr),
      .wdata (m_wdata),
      .rdata (mem_q)
   );

   // ---------------- status to the sequencer ----------------
   assign acc_zero = (acc_q == '0);
   assign opcode   = ir_q[WORD_W-1 -: OPC_W];
endmodule

// File: rtl/acc_dp_chk.sv
module acc_dp_chk #(
   parameter int unsigned ADDR_W = 10,
   parameter int unsigned OPC_W  = 2
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    drv_acc,
   input logic                    drv_ir,
   input logic                    drv_pc,
   input logic                    drv_mdr,
   input logic                    drv_tmp,
   input logic                    ld_acc,
   input logic                    ld_pc,
   input logic                    ld_mar,
   input logic                    inc_pc,
   input logic                    add_en,
   input logic [ADDR_W-1:0]       pc_q,
   input logic [ADDR_W-1:0]       mar_q,
   input logic [ADDR_W+OPC_W-1:0] ir_q,
   input logic [ADDR_W+OPC_W-1:0] mdr_q,
   input logic [ADDR_W+OPC_W-1:0] acc_q,
   input logic [ADDR_W+OPC_W-1:0] tmp_q
);
   localparam int unsigned WORD_W = ADDR_W + OPC_W;

   a_r2_single_driver: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({drv_acc, drv_ir, drv_pc, drv_mdr, drv_tmp}));

   a_r2_ir_addr_only: assert property (@(posedge clk) disable iff (!rst_n)
      (drv_ir && ld_acc) |=> (acc_q[WORD_W-1 -: OPC_W] == '0));

   a_r3_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_acc |=> $stable(acc_q));

   a_r3_mar_from_pc: assert property (@(posedge clk) disable iff (!rst_n)
      (drv_pc && ld_mar) |=> (mar_q == $past(pc_q)));

   a_r6_add_into_tmp: assert property (@(posedge clk) disable iff (!rst_n)
      (drv_acc && add_en) |=> (tmp_q == WORD_W'($past(acc_q) + $past(mdr_q))));

   a_r7_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_pc && !ld_pc) |=> (pc_q == ADDR_W'($past(pc_q) + 1'b1)));

   a_r7_pc_from_ir: assert property (@(posedge clk) disable iff (!rst_n)
      (drv_ir && ld_pc) |=> (pc_q == $past(ir_q[ADDR_W-1:0])));
endmodule

bind acc_bus_datapath acc_dp_chk #(.ADDR_W(ADDR_W), .OPC_W(OPC_W)) u_chk (.*);

// File: tb/tb_acc_bus_datapath.sv
module tb_acc_bus_datapath;
   localparam int LD_ACC = 0,  DRV_ACC = 1,  LD_IR = 2,   DRV_IR = 3;
   localparam int LD_PC  = 4,  DRV_PC  = 5,  LD_MAR = 6,  LD_MDR = 7;
   localparam int DRV_MDR = 8, DRV_TMP = 9,  INC_PC = 10, RD = 11;
   localparam int WR = 12,     ADD = 13;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [13:0] st = '0;
   logic pre_we = 1'b0;
   logic [9:0] pre_addr = '0;
   logic [11:0] pre_data = '0;
   logic acc_zero;
   logic [1:0] opcode;
   logic [9:0] pc_q, mar_q;
   logic [11:0] ir_q, mdr_q, acc_q, tmp_q;

   always #10 clk = ~clk;   // 50 MHz

   acc_bus_datapath dut (
      .clk(clk), .rst_n(rst_n),
      .ld_acc(st[LD_ACC]), .drv_acc(st[DRV_ACC]), .ld_ir(st[LD_IR]), .drv_ir(st[DRV_IR]),
      .ld_pc(st[LD_PC]), .drv_pc(st[DRV_PC]), .inc_pc(st[INC_PC]), .ld_mar(st[LD_MAR]),
      .ld_mdr(st[LD_MDR]), .drv_mdr(st[DRV_MDR]), .mem_rd(st[RD]), .mem_wr(st[WR]),
      .add_en(st[ADD]), .drv_tmp(st[DRV_TMP]),
      .pre_we(pre_we), .pre_addr(pre_addr), .pre_data(pre_data),
      .acc_zero(acc_zero), .opcode(opcode),
      .pc_q(pc_q), .mar_q(mar_q), .ir_q(ir_q), .mdr_q(mdr_q), .acc_q(acc_q), .tmp_q(tmp_q)
   );

   // behavioural reference state
   int m_mem [1024];
   int m_pc, m_mar, m_ir, m_mdr, m_acc, m_tmp;
   int n_cmp = 0, n_bad = 0;
   string cur_req = "R1";

   function automatic logic [13:0] b(int idx);
      return 14'(1) << idx;
   endfunction

   task automatic chk(string what, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
      end
   endtask

   task automatic compare_all();
      chk("pc", int'(pc_q), m_pc);
      chk("mar", int'(mar_q), m_mar);
      chk("ir", int'(ir_q), m_ir);
      chk("mdr", int'(mdr_q), m_mdr);
      chk("acc", int'(acc_q), m_acc);
      chk("tmp", int'(tmp_q), m_tmp);
      chk("acc_zero (R8)", int'(acc_zero), (m_acc == 0) ? 1 : 0);
      chk("opcode (R8)", int'(opcode), (m_ir >> 10) & 3);
   endtask

   task automatic finish_up();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   // one cycle: called at a falling edge, returns at the next falling edge after comparing
   task automatic step(logic [13:0] s);
      int bus, n_pc, n_mar, n_ir, n_mdr, n_acc, n_tmp;
      st = s;
      bus = 0;
      if (s[DRV_ACC]) bus = m_acc;
      if (s[DRV_IR])  bus = m_ir & 'h3ff;
      if (s[DRV_PC])  bus = m_pc;
      if (s[DRV_MDR]) bus = m_mdr;
      if (s[DRV_TMP]) bus = m_tmp;
      n_acc = s[LD_ACC] ? bus : m_acc;
      n_ir  = s[LD_IR]  ? bus : m_ir;
      n_mar = s[LD_MAR] ? (bus & 'h3ff) : m_mar;
      n_pc  = s[LD_PC]  ? (bus & 'h3ff) : (s[INC_PC] ? ((m_pc + 1) & 'h3ff) : m_pc);
      n_mdr = s[LD_MDR] ? bus : (s[RD] ? m_mem[m_mar] : m_mdr);
      n_tmp = s[ADD]    ? ((bus + m_mdr) & 'hfff) : m_tmp;
      if (s[WR]) m_mem[m_mar] = m_mdr;
      @(posedge clk);
      @(negedge clk);
      m_acc = n_acc; m_ir = n_ir; m_mar = n_mar; m_pc = n_pc; m_mdr = n_mdr; m_tmp = n_tmp;
      compare_all();
   endtask

   task automatic fetch();
      step(b(LD_MAR) | b(DRV_PC));
      step(b(INC_PC) | b(RD));
      step(b(LD_IR) | b(DRV_MDR));
   endtask

   task automatic op_load();
      step(b(DRV_IR) | b(LD_MAR));
      step(b(RD));
      step(b(LD_ACC) | b(DRV_MDR));
   endtask

   task automatic op_add();
      step(b(DRV_IR) | b(LD_MAR));
      step(b(RD));
      step(b(DRV_ACC) | b(ADD));
      step(b(LD_ACC) | b(DRV_TMP));
   endtask

   task automatic op_store();
      step(b(DRV_IR) | b(LD_MAR));
      step(b(DRV_ACC) | b(LD_MDR));
      step(b(WR));
   endtask

   task automatic op_brz();
      if (m_acc == 0) step(b(DRV_IR) | b(LD_PC));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog (all requirements): actual hung expected finished");
      finish_up();
   end

   initial begin
      int prog [11] = '{'h008, 'h409, 'hc06, 'h409, 'hc06, 'h409, 'h80a, 'hfff, 'h002, 'hfff, 'h005};
      m_pc = 0; m_mar = 0; m_ir = 0; m_mdr = 0; m_acc = 0; m_tmp = 0;
      // R9: fill the whole memory through the preload port while in reset
      @(negedge clk);
      for (int i = 0; i < 1024; i++) begin
         m_mem[i] = (i < 11) ? prog[i] : int'($urandom & 'hfff);
         pre_we = 1'b1; pre_addr = 10'(i); pre_data = 12'(m_mem[i]);
         @(negedge clk);
      end
      pre_we = 1'b0;
      cur_req = "R1";
      compare_all();
      rst_n = 1'b1;
      @(negedge clk);
      compare_all();

      // short program: load, add with wrap, branch not taken / taken, store
      cur_req = "R4";
      fetch(); op_load();
      chk("acc after load (R4)", int'(acc_q), 2);
      cur_req = "R6";
      fetch(); op_add();
      chk("tmp 2+fff (R6)", int'(tmp_q), 1);
      cur_req = "R7";
      fetch(); op_brz();
      chk("pc after untaken branch (R7)", int'(pc_q), 3);
      cur_req = "R6";
      fetch(); op_add();
      cur_req = "R7";
      fetch(); op_brz();
      chk("pc after taken branch (R7)", int'(pc_q), 6);
      cur_req = "R5";
      fetch(); op_store();
      step(b(DRV_IR) | b(LD_MAR));
      step(b(RD));
      chk("stored word read back (R5)", int'(mdr_q), 0);

      // R2: undriven bus gives zero; IR puts only its address field on the bus
      cur_req = "R2";
      step(b(LD_ACC));
      chk("acc from idle bus (R2)", int'(acc_q), 0);
      step(b(DRV_IR) | b(LD_ACC));
      chk("acc from IR field (R2)", int'(acc_q), 'h00a);

      // R7: wrap and priority
      cur_req = "R7";
      fetch();                                   // IR = fff
      step(b(DRV_IR) | b(LD_PC));
      chk("pc loaded 3ff (R7)", int'(pc_q), 'h3ff);
      step(b(INC_PC));
      chk("pc wraps to 0 (R7)", int'(pc_q), 0);
      step(b(DRV_IR) | b(LD_PC) | b(INC_PC));
      chk("load beats increment (R7)", int'(pc_q), 'h3ff);

      // R4: bus load into MDR beats memory read
      cur_req = "R4";
      step(b(DRV_IR) | b(LD_ACC));
      step(b(DRV_ACC) | b(LD_MDR) | b(RD));
      chk("mdr takes bus over memory (R4)", int'(mdr_q), 'h3ff);

      // R5: read in the write cycle returns the old word
      cur_req = "R5";
      step(b(DRV_PC) | b(LD_MAR));
      step(b(WR) | b(RD));
      step(b(RD));
      chk("word now holds old mdr (R5)", int'(mdr_q), 'h3ff);

      // R9: preload ignored while running
      cur_req = "R9";
      pre_we = 1'b1; pre_addr = mar_q; pre_data = 12'hABC;
      step('0);
      pre_we = 1'b0;
      step(b(RD));
      chk("preload ignored out of reset (R9)", int'(mdr_q), m_mem[m_mar]);

      // R3: random register transfers against the model
      cur_req = "R3";
      for (int k = 0; k < 3000; k++) begin
         logic [13:0] s;
         int d;
         s = '0;
         d = int'($urandom % 6);
         case (d)
            1: s[DRV_ACC] = 1'b1;
            2: s[DRV_IR]  = 1'b1;
            3: s[DRV_PC]  = 1'b1;
            4: s[DRV_MDR] = 1'b1;
            5: s[DRV_TMP] = 1'b1;
            default: ;
         endcase
         s[LD_ACC] = ($urandom % 3) == 0;
         s[LD_IR]  = ($urandom % 4) == 0;
         s[LD_PC]  = ($urandom % 6) == 0;
         s[LD_MAR] = ($urandom % 3) == 0;
         s[LD_MDR] = ($urandom % 6) == 0;
         s[INC_PC] = ($urandom % 3) == 0;
         s[RD]     = ($urandom % 3) == 0;
         s[WR]     = ($urandom % 5) == 0;
         s[ADD]    = ($urandom % 3) == 0;
         pre_we = (($urandom % 8) == 0);   // R9: must stay without effect
         pre_addr = mar_q; pre_data = 12'($urandom);
         step(s);
      end
      pre_we = 1'b0;
      st = '0;
      finish_up();
   end
endmodule